// File: doc/BRIEF.md
# Polarity-Selectable Edge-Detect Interrupt Unit

This block watches the lower 24 lines of a digital I/O port bank, grouped as three 8-bit ports, and raises an interrupt request when an enabled line makes a transition of the selected direction. Each line has its own direction select and its own enable. A detected transition sets a sticky flag that stays set until the host clears it. Each port has a summary bit that shows whether any of its flags is set. The interrupt request is the OR of those three summary bits.

The host reaches the per-line registers through three shared offsets (0x8, 0x9 and 0xA, one per port), and a 2-bit page field picks which register bank those offsets address. That page field comes from a neighbouring page register. Page 1 selects the write-only direction registers, page 2 the write-only enable registers, and page 3 the readable and clearable flag registers. The summary is readable at offset 0x6 on every page. Pad levels are asynchronous and are synchronized inside the block before they are compared.

Top module: `edet_irq_unit`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), every direction, enable and flag bit is 0, so port_pend, irq_req and every flag read are 0.
- R2: A write on page 1 (page_sel = 1) to offset 0x8+n sets the direction of port n's lines: a 1 bit detects rising transitions and a 0 bit detects falling ones. A read on page 1 or page 2 at offsets 0x8 to 0xA returns 0.
- R3: A write on page 2 to offset 0x8+n sets the enables of port n. A transition on a disabled line sets no flag.
- R4: A read on page 3 at offset 0x8+n returns port n's flag byte, where bit b is line 8n+b.
- R5: A read at offset 0x6, on any page, returns the three summary bits in bits 2:0 (bit n = any flag of port n) and 0 in bits 7:3. Every other unlisted read returns 0.
- R6: A write on page 3 to offset 0x8+n clears the flags of port n whose data bits are 0 and keeps those whose data bits are 1.
- R7: A qualified transition that is detected in the same cycle as a clearing write to its bit leaves that flag set.
- R8: Clearing an enable bit leaves a flag already captured on that line set.
- R9: irq_req is 1 exactly when at least one summary bit is 1.
- R10: A pad level that changes before clock edge k, and stays stable, first shows on port_pend and irq_req after edge k+2 and not after edge k+1.
- R11: Writes on page 0, and writes to offset 0x6 on any page, change no direction, enable or flag bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pad_in | input | 24 | Asynchronous pad levels, line 8n+b is port n bit b |
| page_sel | input | 2 | Page field choosing the bank behind offsets 0x8 to 0xA |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | 4 | Host register offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr and page_sel |
| port_pend | output | 3 | Per-port summary, bit n = any flag of port n |
| irq_req | output | 1 | Interrupt request |

## Verification
Flag, direction and enable state are held only in the block, so a wrong bit shows up late at the ports. A wrong direction or enable bit shows nothing until a transition reaches that line, and then a flag appears or fails to appear two edges after the pad changes. A wrong flag bit shows at once in the summary, in irq_req and in the page-3 read. The bench keeps a behavioural model one edge behind the pads and compares its summary, request and read data with the outputs on every cycle, so a fault is reported in the cycle where it first becomes visible.

// File: rtl/edet_pkg.sv
// Shared constants and the page encoding for the edge-detect interrupt unit.
// Assumes the host decodes the block's register window to a 4-bit offset.
package edet_pkg;
    localparam int LINE_W      = 8;   // lines per port, also the data width
    localparam int EDGE_PORTS  = 3;   // ports that can detect transitions
    localparam int ADDR_W      = 4;   // host offset width
    localparam int SYNC_STAGES = 2;   // synchronizer depth on the pads
    localparam int PEND_OFS    = 6;   // summary register offset
    localparam int PAGED_BASE  = 8;   // first paged offset, port 0

    // Bank selected behind the paged offsets
    typedef enum logic [1:0] {
        PG_PORTS = 2'd0,
        PG_POL   = 2'd1,
        PG_ENB   = 2'd2,
        PG_FLAG  = 2'd3
    } page_e;
endpackage

// File: rtl/edet_sync.sv
// Multi-stage level synchronizer for asynchronous pad inputs.
// Assumes each pad bit is an independent level; no bus coherency is implied.
module edet_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the raw pads
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d_i;
            end
        end else begin : g_next
            // Later stages resolve metastability of the one before
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/edet_port_slice.sv
// One port of edge detection: direction, enable, previous level and sticky
// flags for W lines. Assumes lvl_i is already synchronized to clk.
// A qualified transition in the same cycle as a clearing write wins.
module edet_port_slice #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic         pol_we_i,
    input  logic         enb_we_i,
    input  logic         flag_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] flags_o,
    output logic         any_o
);
    logic [W-1:0] pol_q;
    logic [W-1:0] enb_q;
    logic [W-1:0] prev_q;
    logic [W-1:0] flag_q;
    logic [W-1:0] hit;
    logic [W-1:0] keep;

    // Per-line transition qualification by direction and enable
    for (genvar b = 0; b < W; b++) begin : g_line
        logic went_up;
        logic went_down;
        assign went_up   = lvl_i[b] & ~prev_q[b];
        assign went_down = ~lvl_i[b] & prev_q[b];
        assign hit[b]    = enb_q[b] & (pol_q[b] ? went_up : went_down);
    end

    // Clear mask: bits written 0 go away, bits written 1 stay
    always_comb begin
        keep = '1;
        if (flag_we_i) keep = wdata_i;
    end

    // Direction register
    always_ff @(posedge clk) begin
        if (!rst_n)        pol_q <= '0;
        else if (pol_we_i) pol_q <= wdata_i;
    end

    // Enable register
    always_ff @(posedge clk) begin
        if (!rst_n)        enb_q <= '0;
        else if (enb_we_i) enb_q <= wdata_i;
    end

    // Previous synchronized level for transition detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    // Sticky flags: masked clear first, then new hits are ORed in
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & keep) | hit;
    end

    assign flags_o = flag_q;
    assign any_o   = |flag_q;
endmodule

// File: rtl/edet_regif.sv
// Host register decode for the edge-detect unit: turns offset, page and write
// strobe into per-port write enables and builds the combinational read data.
// Assumes PORTS <= W so the summary fits one data word.
module edet_regif
    import edet_pkg::*;
#(
    parameter int PORTS  = 3,
    parameter int W      = 8,
    parameter int AW     = 4,
    localparam int NBITS = PORTS * W
) (
    input  logic             wr_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [1:0]       page_i,
    input  logic [NBITS-1:0] flags_i,
    input  logic [PORTS-1:0] pend_i,
    output logic [PORTS-1:0] pol_we_o,
    output logic [PORTS-1:0] enb_we_o,
    output logic [PORTS-1:0] flag_we_o,
    output logic [W-1:0]     rdata_o
);
    logic is_pol;
    logic is_enb;
    logic is_flag;

    assign is_pol  = (page_i == PG_POL);
    assign is_enb  = (page_i == PG_ENB);
    assign is_flag = (page_i == PG_FLAG);

    // One write enable per port and bank
    for (genvar p = 0; p < PORTS; p++) begin : g_dec
        logic at_port;
        assign at_port      = (addr_i == AW'(PAGED_BASE + p));
        assign pol_we_o[p]  = wr_i & at_port & is_pol;
        assign enb_we_o[p]  = wr_i & at_port & is_enb;
        assign flag_we_o[p] = wr_i & at_port & is_flag;
    end

    // Read mux: summary on any page, flags on the flag page, else zero
    always_comb begin
        rdata_o = '0;
        if (addr_i == AW'(PEND_OFS)) rdata_o[PORTS-1:0] = pend_i;
        for (int p = 0; p < PORTS; p++) begin
            if (is_flag && addr_i == AW'(PAGED_BASE + p))
                rdata_o = flags_i[p*W +: W];
        end
    end
endmodule

// File: rtl/edet_irq_unit.sv
// Edge-detect interrupt unit for the lower ports of a digital I/O bank.
// Synchronizes the pads, detects per-line transitions of the selected
// direction on enabled lines, holds sticky flags and drives a per-port
// summary and a single request. Assumes page_sel comes from a neighbouring
// page register and that bus_wr is a one-cycle strobe.
module edet_irq_unit
    import edet_pkg::*;
#(
    parameter int PORTS   = EDGE_PORTS,
    parameter int W       = LINE_W,
    parameter int AW      = ADDR_W,
    parameter int STAGES  = SYNC_STAGES,
    localparam int NLINES = PORTS * W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] pad_in,
    input  logic [1:0]        page_sel,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic [PORTS-1:0]  port_pend,
    output logic              irq_req
);
    logic [NLINES-1:0] lvl;
    logic [NLINES-1:0] flags;
    logic [PORTS-1:0]  pol_we;
    logic [PORTS-1:0]  enb_we;
    logic [PORTS-1:0]  flag_we;

    edet_sync #(.W(NLINES), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pad_in),
        .q_o   (lvl)
    );

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        edet_port_slice #(.W(W)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl_i     (lvl[p*W +: W]),
            .pol_we_i  (pol_we[p]),
            .enb_we_i  (enb_we[p]),
            .flag_we_i (flag_we[p]),
            .wdata_i   (bus_wdata),
            .flags_o   (flags[p*W +: W]),
            .any_o     (port_pend[p])
        );
    end

    edet_regif #(.PORTS(PORTS), .W(W), .AW(AW)) u_regif (
        .wr_i      (bus_wr),
        .addr_i    (bus_addr),
        .page_i    (page_sel),
        .flags_i   (flags),
        .pend_i    (port_pend),
        .pol_we_o  (pol_we),
        .enb_we_o  (enb_we),
        .flag_we_o (flag_we),
        .rdata_o   (bus_rdata)
    );

    // Single request from the port summaries
    assign irq_req = |port_pend;
endmodule

// File: rtl/edet_irq_chk.sv
// Port-level checker for edet_irq_unit, attached by bind below.
module edet_irq_chk
    import edet_pkg::*;
#(
    parameter int PORTS   = EDGE_PORTS,
    parameter int W       = LINE_W,
    parameter int AW      = ADDR_W,
    localparam int NLINES = PORTS * W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NLINES-1:0] pad_in,
    input logic [1:0]        page_sel,
    input logic              bus_wr,
    input logic [AW-1:0]     bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      bus_rdata,
    input logic [PORTS-1:0]  port_pend,
    input logic              irq_req
);
    // R1: first cycle out of reset shows nothing pending
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (port_pend == '0 && !irq_req));

    // R5: summary read matches the summary port, upper bits zero
    a_r5_pend_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(PEND_OFS)) |->
            (bus_rdata == {{(W-PORTS){1'b0}}, port_pend}));

    // R9: request agrees with the summary read
    a_r9_irq_vs_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(PEND_OFS)) |-> ((bus_rdata != '0) == irq_req));

    for (genvar n = 0; n < PORTS; n++) begin : g_chk
        // R2: direction and enable banks read back as zero
        a_r2_write_only: assert property (@(posedge clk) disable iff (!rst_n)
            ((page_sel == PG_POL || page_sel == PG_ENB) &&
             bus_addr == AW'(PAGED_BASE + n)) |-> (bus_rdata == '0));

        // R4: a flag read is nonzero exactly when the port is pending
        a_r4_id_vs_pend: assert property (@(posedge clk) disable iff (!rst_n)
            (page_sel == PG_FLAG && bus_addr == AW'(PAGED_BASE + n)) |->
                ((bus_rdata != '0) == port_pend[n]));

        // R8: a summary bit only drops after a write to that port's flags
        a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(port_pend[n]) |->
                $past(bus_wr && page_sel == PG_FLAG &&
                      bus_addr == AW'(PAGED_BASE + n)));

        // R10: a summary bit only rises from a pad change three edges back
        a_r10_edge_origin: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(port_pend[n]) |->
                ($past(pad_in[n*W +: W], 3) != $past(pad_in[n*W +: W], 4)));
    end
endmodule

bind edet_irq_unit edet_irq_chk #(.PORTS(PORTS), .W(W), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_in    (pad_in),
    .page_sel  (page_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .port_pend (port_pend),
    .irq_req   (irq_req)
);

// File: tb/edet_irq_unit_tb.sv
// Bench: behavioural model one edge behind the pads, compared every cycle,
// plus directed checks per requirement.
module edet_irq_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pad = '0;
    logic [1:0]  page = '0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [2:0]  pend;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state
    logic [23:0] m_s1 = '0, m_s2 = '0, m_prev = '0;
    logic [23:0] m_pol = '0, m_en = '0, m_flag = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edet_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .pad_in(pad), .page_sel(page),
        .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .port_pend(pend), .irq_req(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] m_pend();
        logic [2:0] r;
        for (int p = 0; p < 3; p++) r[p] = |m_flag[p*8 +: 8];
        return r;
    endfunction

    function automatic logic [7:0] m_read(input logic [1:0] pg, input logic [3:0] a);
        if (a == 4'd6) return {5'b0, m_pend()};
        if (pg == 2'd3 && a >= 4'd8 && a <= 4'd10) return m_flag[int'(a - 4'd8)*8 +: 8];
        return 8'h00;
    endfunction

    // Model update at each edge, then compare a quarter period later
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0;
            m_pol = '0; m_en = '0; m_flag = '0;
        end else begin
            logic [23:0] nflag;
            nflag = m_flag;
            if (wr && page == 2'd3 && addr >= 4'd8 && addr <= 4'd10)
                for (int b = 0; b < 8; b++)
                    if (!wdata[b]) nflag[int'(addr - 4'd8)*8 + b] = 1'b0;
            for (int i = 0; i < 24; i++) begin
                bit up, down;
                up   = m_s2[i] && !m_prev[i];
                down = !m_s2[i] && m_prev[i];
                if (m_en[i] && (m_pol[i] ? up : down)) nflag[i] = 1'b1;
            end
            m_flag = nflag;
            if (wr && addr >= 4'd8 && addr <= 4'd10) begin
                if (page == 2'd1) m_pol[int'(addr - 4'd8)*8 +: 8] = wdata;
                if (page == 2'd2) m_en[int'(addr - 4'd8)*8 +: 8]  = wdata;
            end
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pad;
        end
        #3;
        if (rst_n && !done) begin
            chk("R5 summary vs model", pend, m_pend());
            chk("R9 request vs model", irq, |m_pend());
            chk("R4 read vs model", rdata, m_read(page, addr));
        end
    end

    task automatic bus_write(input logic [1:0] pg, input logic [3:0] a, input logic [7:0] d);
        page = pg; addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; addr = 4'd0; page = 2'd0;
    endtask

    task automatic bus_read(input string tag, input logic [1:0] pg, input logic [3:0] a,
                            input logic [7:0] exp);
        page = pg; addr = a;
        #1;
        chk(tag, rdata, exp);
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 summary after reset", pend, 3'b000);
        chk("R1 request after reset", irq, 1'b0);
        bus_read("R1 flags port0", 2'd3, 4'd8, 8'h00);
        bus_read("R1 flags port2", 2'd3, 4'd10, 8'h00);

        // Configure: port0 rising, low nibble enabled; port1 falling all on
        bus_write(2'd1, 4'd8, 8'hFF);
        bus_write(2'd2, 4'd8, 8'h0F);
        bus_write(2'd1, 4'd9, 8'h00);
        bus_write(2'd2, 4'd9, 8'hFF);
        bus_write(2'd1, 4'd10, 8'h01);
        bus_write(2'd2, 4'd10, 8'h03);

        // R10: latency of a rising change on port0
        pad[7:0] = 8'hFF;
        @(posedge clk); @(posedge clk); #3;
        chk("R10 not yet after edge k+1", pend[0], 1'b0);
        @(posedge clk); #3;
        chk("R10 visible after edge k+2", pend[0], 1'b1);
        @(negedge clk);
        // R3: only enabled lines flagged; R2 rising
        bus_read("R3 enabled lines only", 2'd3, 4'd8, 8'h0F);

        // R2: falling direction ignores rising, catches falling
        pad[15:8] = 8'hFF; settle();
        bus_read("R2 rising ignored on falling port", 2'd3, 4'd9, 8'h00);
        pad[15:8] = 8'h0F; settle();
        bus_read("R2 falling caught", 2'd3, 4'd9, 8'hF0);

        // R5 and R9
        bus_read("R5 summary read", 2'd2, 4'd6, 8'h03);
        chk("R9 request set", irq, 1'b1);
        // R2: write-only banks read zero
        bus_read("R2 direction reads zero", 2'd1, 4'd8, 8'h00);
        bus_read("R2 enable reads zero", 2'd2, 4'd9, 8'h00);

        // R11: writes with no target change nothing
        bus_write(2'd0, 4'd8, 8'h00);
        bus_write(2'd0, 4'd9, 8'h00);
        bus_write(2'd3, 4'd6, 8'h00);
        bus_write(2'd1, 4'd6, 8'h00);
        bus_read("R11 port0 flags kept", 2'd3, 4'd8, 8'h0F);
        bus_read("R11 port1 flags kept", 2'd3, 4'd9, 8'hF0);
        pad[7:0] = 8'h00; settle();
        pad[7:0] = 8'hF1; settle();
        bus_read("R11 port0 config kept", 2'd3, 4'd8, 8'h0F);

        // R6: masked clear
        bus_write(2'd3, 4'd8, 8'hF5);
        bus_read("R6 masked clear", 2'd3, 4'd8, 8'h05);

        // R8: disable keeps captured flags; R3 new edges ignored
        bus_write(2'd2, 4'd8, 8'h00);
        pad[7:0] = 8'h00; settle();
        pad[7:0] = 8'hFF; settle();
        bus_read("R8 flags kept after disable", 2'd3, 4'd8, 8'h05);

        // R7: clear colliding with a new edge on port2 bit0
        pad[17] = 1'b1; settle();
        pad[17] = 1'b0; settle();
        bus_read("R7 setup falling flag", 2'd3, 4'd10, 8'h02);
        pad[16] = 1'b1;
        repeat (2) @(negedge clk);
        bus_write(2'd3, 4'd10, 8'h00);
        settle();
        bus_read("R7 edge beats clear", 2'd3, 4'd10, 8'h01);

        // R9: clearing everything drops the request
        bus_write(2'd3, 4'd8, 8'h00);
        bus_write(2'd3, 4'd9, 8'h00);
        bus_write(2'd3, 4'd10, 8'h00);
        @(negedge clk);
        chk("R9 request clear", irq, 1'b0);
        bus_read("R5 summary clear", 2'd0, 4'd6, 8'h00);

        finish_run();
    end
endmodule